// File: doc/BRIEF.md
# Task Frame Register File

This block keeps the architectural state of four resident hardware threads. Each thread owns a task frame: a bank of frame-local general registers, a program counter with its next-PC successor, a 32-bit status word, a group of eight floating-point registers and its own floating-point condition bits. Eight global registers sit beside the frames and are reachable from any of them. A current frame pointer picks the active frame. Every register access and every fetch address is resolved through it.

Software moves the frame pointer by stepping it up or down, which wraps around the frame count, or by loading it directly. Its value is always visible so that it can be copied into a register. The memory system can also force a context switch when a thread misses remotely or fails a full/empty synchronisation. The request is honoured only once the pipeline reports that it has drained. The outgoing frame's PC chain is left untouched. The pointer advances to the next frame, and fetch resumes from that frame's saved PC after a fixed four-cycle gap. A trap changes only the PC chain of the active frame, so its handler runs in the same frame as the thread that trapped.

Top module: `task_frame_regfile`

## Requirements
- R1: After reset the frame pointer is 0, fetch is valid, and the fetch address is frame 0's start PC. Frame f starts with PC = PC_BASE + f*PC_STRIDE and next-PC = PC + 4. All registers, status words, floating-point registers and condition bits are zero.
- R2: Register indices 0 to 7 name the eight global registers. A write to one of them is read back unchanged whatever the frame pointer is.
- R3: Register indices 8 to 31 name frame-local registers of the active frame. A write in one frame is not visible in any other frame.
- R4: fp_op encodes 0 = hold, 1 = step up, 2 = step down, 3 = load. Stepping up from 3 gives 0 and stepping down from 0 gives 3. The new value shows on cur_fp after the edge.
- R5: fp_op = 3 loads fp_load_val into the frame pointer. cur_fp always shows the current frame pointer.
- R6: fetch_pc is the PC of the active frame. pc_step moves PC to next-PC and next-PC to next-PC + 4 in that frame only.
- R7: trap_take sets the active frame's PC to trap_vec and next-PC to trap_vec + 4. The frame pointer is not changed, and trap_take has priority over pc_step.
- R8: switch_req is acted on only in a cycle with pipe_drained high. Without pipe_drained it changes nothing.
- R9: An accepted switch moves the frame pointer to (fp + 1) mod 4 and keeps the outgoing frame's PC chain. fetch_valid is low for exactly 4 cycles, and then fetch_pc shows the new frame's saved PC.
- R10: While a switch is in progress, and on the accepting edge itself, pc_step, trap_take and fp_op have no effect, and further switch requests are ignored.
- R11: Each frame has its own status word. psr_wr_en writes the active frame's word, and psr_rd_data reads it.
- R12: Floating-point register index i (0 to 7) selects word fp*8 + i of the 32-word floating-point file. The two condition bits are kept per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx_a | input | 5 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 5 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Register write index |
| wr_data | input | 32 | Register write data |
| psr_wr_en | input | 1 | Status word write enable |
| psr_wr_data | input | 32 | Status word write data |
| psr_rd_data | output | 32 | Active frame status word |
| fpr_rd_idx | input | 3 | Floating-point read index within the frame group |
| fpr_rd_data | output | 32 | Floating-point read data |
| fpr_wr_en | input | 1 | Floating-point write enable |
| fpr_wr_idx | input | 3 | Floating-point write index within the frame group |
| fpr_wr_data | input | 32 | Floating-point write data |
| fcc_wr_en | input | 1 | Condition bit write enable |
| fcc_wr_data | input | 2 | Condition bit write data |
| fcc_rd_data | output | 2 | Active frame condition bits |
| fp_op | input | 2 | Frame pointer operation |
| fp_load_val | input | 2 | Value for the load operation |
| cur_fp | output | 2 | Current frame pointer |
| switch_req | input | 1 | Forced context switch request |
| pipe_drained | input | 1 | Pipeline has emptied |
| pc_step | input | 1 | Advance the active PC chain |
| trap_take | input | 1 | Redirect the active PC chain to trap_vec |
| trap_vec | input | 32 | Trap target address |
| fetch_pc | output | 32 | Fetch address of the active frame |
| fetch_valid | output | 1 | Fetch address may be used |

## Verification
A behavioural model in the bench is compared with every output on every clock. Directed sequences come first. One writes a global register and reads it back from a different frame, which separates the shared bank from the per-frame banks. Another writes a local register and steps the pointer away, which shows whether frames are isolated. Others step the pointer across both wrap points. The switch sequences hold switch_req high without pipe_drained, then raise pipe_drained, then keep issuing steps, traps, pointer operations and requests during the gap; this separates correct gating from early or late acceptance and from a wrong latency. A long pseudo-random phase then mixes all controls, so that a change to any one frame's state also shows up as a mismatch once that frame becomes active again.

// File: rtl/tfrf_pkg.sv
package tfrf_pkg;
    typedef enum logic [1:0] {
        FPOP_HOLD = 2'd0,
        FPOP_UP   = 2'd1,
        FPOP_DOWN = 2'd2,
        FPOP_LOAD = 2'd3
    } fp_op_e;
endpackage

// File: rtl/tfrf_fp_ctrl.sv
module tfrf_fp_ctrl #(
    parameter int NFRAMES    = 4,
    parameter int SWITCH_LAT = 4,
    localparam int FPW  = $clog2(NFRAMES),
    localparam int CNTW = $clog2(SWITCH_LAT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     fp_op,
    input  logic [FPW-1:0] fp_load_val,
    input  logic           switch_req,
    input  logic           pipe_drained,
    output logic [FPW-1:0] cur_fp,
    output logic           busy,
    output logic           exec_ok
);
    import tfrf_pkg::*;

    typedef struct packed {
        logic [FPW-1:0]  fp;
        logic [CNTW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start;

    function automatic logic [FPW-1:0] fp_next(input logic [FPW-1:0] f);
        return (f == FPW'(NFRAMES - 1)) ? '0 : f + FPW'(1);
    endfunction

    function automatic logic [FPW-1:0] fp_prev(input logic [FPW-1:0] f);
        return (f == '0) ? FPW'(NFRAMES - 1) : f - FPW'(1);
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        start = 1'b0;
        if (ctl_q.cnt != '0) begin
            ctl_d.cnt = ctl_q.cnt - CNTW'(1);
        end else if (switch_req && pipe_drained) begin
            start     = 1'b1;
            ctl_d.fp  = fp_next(ctl_q.fp);
            ctl_d.cnt = CNTW'(SWITCH_LAT);
        end else begin
            unique case (fp_op_e'(fp_op))
                FPOP_UP:   ctl_d.fp = fp_next(ctl_q.fp);
                FPOP_DOWN: ctl_d.fp = fp_prev(ctl_q.fp);
                FPOP_LOAD: ctl_d.fp = (int'(fp_load_val) < NFRAMES) ? fp_load_val : ctl_q.fp;
                default:   ctl_d.fp = ctl_q.fp;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cur_fp  = ctl_q.fp;
    assign busy    = (ctl_q.cnt != '0);
    assign exec_ok = !busy && !start;

    assert_step_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(switch_req && pipe_drained) && fp_op == 2'd1) |=> cur_fp == fp_next($past(cur_fp)));

    assert_step_down_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(switch_req && pipe_drained) && fp_op == 2'd2) |=> cur_fp == fp_prev($past(cur_fp)));

    assert_need_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && switch_req && !pipe_drained && fp_op == 2'd0) |=> $stable(cur_fp));

    assert_busy_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_fp));

    assert_switch_next_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cur_fp == fp_next($past(cur_fp)));
endmodule

// File: rtl/tfrf_gpr_bank.sv
module tfrf_gpr_bank #(
    parameter int XLEN    = 32,
    parameter int NFRAMES = 4,
    parameter int NGLOBAL = 8,
    parameter int NREGIDX = 32,
    localparam int FPW    = $clog2(NFRAMES),
    localparam int IDXW   = $clog2(NREGIDX),
    localparam int GIDXW  = $clog2(NGLOBAL),
    localparam int NLOCAL = NREGIDX - NGLOBAL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FPW-1:0]  cur_fp,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IDXW-1:0] rd_idx_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [IDXW-1:0] rd_idx_b,
    output logic [XLEN-1:0] rd_data_b
);
    typedef struct packed {
        logic [NGLOBAL-1:0][XLEN-1:0]              glb;
        logic [NFRAMES-1:0][NLOCAL-1:0][XLEN-1:0]  loc;
    } bank_t;

    bank_t bank_d, bank_q;

    function automatic logic [XLEN-1:0] pick(input bank_t b, input logic [FPW-1:0] f,
                                             input logic [IDXW-1:0] idx);
        if (int'(idx) < NGLOBAL) return b.glb[idx[GIDXW-1:0]];
        return b.loc[f][IDXW'(idx - IDXW'(NGLOBAL))];
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (int'(wr_idx) < NGLOBAL) bank_d.glb[wr_idx[GIDXW-1:0]] = wr_data;
            else bank_d.loc[cur_fp][IDXW'(wr_idx - IDXW'(NGLOBAL))] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_data_a = pick(bank_q, cur_fp, rd_idx_a);
    assign rd_data_b = pick(bank_q, cur_fp, rd_idx_b);

    assert_local_leaves_globals_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) >= NGLOBAL) |=> $stable(bank_q.glb));

    for (genvar f = 0; f < NFRAMES; f++) begin : g_iso
        assert_frame_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_fp != FPW'(f)) |=> $stable(bank_q.loc[f]));
    end
endmodule

// File: rtl/tfrf_pc_bank.sv
module tfrf_pc_bank #(
    parameter int XLEN      = 32,
    parameter int NFRAMES   = 4,
    parameter int FCCW      = 2,
    parameter logic [31:0] PC_BASE   = 32'h0000_1000,
    parameter logic [31:0] PC_STRIDE = 32'h0000_0100,
    localparam int FPW = $clog2(NFRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FPW-1:0]  cur_fp,
    input  logic            exec_ok,
    input  logic            pc_step,
    input  logic            trap_take,
    input  logic [XLEN-1:0] trap_vec,
    input  logic            psr_wr_en,
    input  logic [XLEN-1:0] psr_wr_data,
    input  logic            fcc_wr_en,
    input  logic [FCCW-1:0] fcc_wr_data,
    output logic [XLEN-1:0] fetch_pc,
    output logic [XLEN-1:0] psr_rd_data,
    output logic [FCCW-1:0] fcc_rd_data
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    typedef struct packed {
        logic [NFRAMES-1:0][XLEN-1:0] pc;
        logic [NFRAMES-1:0][XLEN-1:0] npc;
        logic [NFRAMES-1:0][XLEN-1:0] psr;
        logic [NFRAMES-1:0][FCCW-1:0] fcc;
    } pcs_t;

    pcs_t pcs_d, pcs_q;

    function automatic pcs_t reset_image();
        pcs_t r;
        r = '0;
        for (int f = 0; f < NFRAMES; f++) begin
            r.pc[f]  = XLEN'(PC_BASE + PC_STRIDE * f);
            r.npc[f] = XLEN'(PC_BASE + PC_STRIDE * f) + INSN_BYTES;
        end
        return r;
    endfunction

    always_comb begin
        pcs_d = pcs_q;
        if (psr_wr_en) pcs_d.psr[cur_fp] = psr_wr_data;
        if (fcc_wr_en) pcs_d.fcc[cur_fp] = fcc_wr_data;
        if (exec_ok) begin
            if (trap_take) begin
                pcs_d.pc[cur_fp]  = trap_vec;
                pcs_d.npc[cur_fp] = trap_vec + INSN_BYTES;
            end else if (pc_step) begin
                pcs_d.pc[cur_fp]  = pcs_q.npc[cur_fp];
                pcs_d.npc[cur_fp] = pcs_q.npc[cur_fp] + INSN_BYTES;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcs_q <= reset_image();
        else        pcs_q <= pcs_d;
    end

    assign fetch_pc    = pcs_q.pc[cur_fp];
    assign psr_rd_data = pcs_q.psr[cur_fp];
    assign fcc_rd_data = pcs_q.fcc[cur_fp];

    assert_trap_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_ok && trap_take) |=> pcs_q.pc[$past(cur_fp)] == $past(trap_vec));

    for (genvar f = 0; f < NFRAMES; f++) begin : g_keep
        assert_idle_chain_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_fp != FPW'(f)) |=> ($stable(pcs_q.pc[f]) && $stable(pcs_q.npc[f])));
        assert_idle_psr_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_fp != FPW'(f)) |=> $stable(pcs_q.psr[f]));
    end
endmodule

// File: rtl/tfrf_fpr_bank.sv
module tfrf_fpr_bank #(
    parameter int XLEN      = 32,
    parameter int NFRAMES   = 4,
    parameter int FPR_WORDS = 32,
    localparam int FPW     = $clog2(NFRAMES),
    localparam int FPR_PER = FPR_WORDS / NFRAMES,
    localparam int FIDXW   = $clog2(FPR_PER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FPW-1:0]   cur_fp,
    input  logic [FIDXW-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    input  logic             wr_en,
    input  logic [FIDXW-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data
);
    typedef struct packed {
        logic [NFRAMES-1:0][FPR_PER-1:0][XLEN-1:0] word;
    } fpr_t;

    fpr_t fpr_d, fpr_q;

    always_comb begin
        fpr_d = fpr_q;
        if (wr_en) fpr_d.word[cur_fp][wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fpr_q <= '0;
        else        fpr_q <= fpr_d;
    end

    assign rd_data = fpr_q.word[cur_fp][rd_idx];

    for (genvar g = 0; g < NFRAMES; g++) begin : g_grp
        assert_fpr_group_isolated_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_fp != FPW'(g)) |=> $stable(fpr_q.word[g]));
    end
endmodule

// File: rtl/task_frame_regfile.sv
module task_frame_regfile #(
    parameter int XLEN       = 32,
    parameter int NFRAMES    = 4,
    parameter int NGLOBAL    = 8,
    parameter int NREGIDX    = 32,
    parameter int FPR_WORDS  = 32,
    parameter int FCCW       = 2,
    parameter int SWITCH_LAT = 4,
    parameter logic [31:0] PC_BASE   = 32'h0000_1000,
    parameter logic [31:0] PC_STRIDE = 32'h0000_0100,
    localparam int FPW   = $clog2(NFRAMES),
    localparam int IDXW  = $clog2(NREGIDX),
    localparam int FIDXW = $clog2(FPR_WORDS / NFRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDXW-1:0]  rd_idx_a,
    output logic [XLEN-1:0]  rd_data_a,
    input  logic [IDXW-1:0]  rd_idx_b,
    output logic [XLEN-1:0]  rd_data_b,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             psr_wr_en,
    input  logic [XLEN-1:0]  psr_wr_data,
    output logic [XLEN-1:0]  psr_rd_data,
    input  logic [FIDXW-1:0] fpr_rd_idx,
    output logic [XLEN-1:0]  fpr_rd_data,
    input  logic             fpr_wr_en,
    input  logic [FIDXW-1:0] fpr_wr_idx,
    input  logic [XLEN-1:0]  fpr_wr_data,
    input  logic             fcc_wr_en,
    input  logic [FCCW-1:0]  fcc_wr_data,
    output logic [FCCW-1:0]  fcc_rd_data,
    input  logic [1:0]       fp_op,
    input  logic [FPW-1:0]   fp_load_val,
    output logic [FPW-1:0]   cur_fp,
    input  logic             switch_req,
    input  logic             pipe_drained,
    input  logic             pc_step,
    input  logic             trap_take,
    input  logic [XLEN-1:0]  trap_vec,
    output logic [XLEN-1:0]  fetch_pc,
    output logic             fetch_valid
);
    logic busy, exec_ok;

    tfrf_fp_ctrl #(.NFRAMES(NFRAMES), .SWITCH_LAT(SWITCH_LAT)) u_fp (
        .clk(clk), .rst_n(rst_n), .fp_op(fp_op), .fp_load_val(fp_load_val),
        .switch_req(switch_req), .pipe_drained(pipe_drained),
        .cur_fp(cur_fp), .busy(busy), .exec_ok(exec_ok)
    );

    tfrf_gpr_bank #(.XLEN(XLEN), .NFRAMES(NFRAMES), .NGLOBAL(NGLOBAL), .NREGIDX(NREGIDX)) u_gpr (
        .clk(clk), .rst_n(rst_n), .cur_fp(cur_fp),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
    );

    tfrf_pc_bank #(.XLEN(XLEN), .NFRAMES(NFRAMES), .FCCW(FCCW),
                   .PC_BASE(PC_BASE), .PC_STRIDE(PC_STRIDE)) u_pc (
        .clk(clk), .rst_n(rst_n), .cur_fp(cur_fp), .exec_ok(exec_ok),
        .pc_step(pc_step), .trap_take(trap_take), .trap_vec(trap_vec),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
        .fcc_wr_en(fcc_wr_en), .fcc_wr_data(fcc_wr_data),
        .fetch_pc(fetch_pc), .psr_rd_data(psr_rd_data), .fcc_rd_data(fcc_rd_data)
    );

    tfrf_fpr_bank #(.XLEN(XLEN), .NFRAMES(NFRAMES), .FPR_WORDS(FPR_WORDS)) u_fpr (
        .clk(clk), .rst_n(rst_n), .cur_fp(cur_fp),
        .rd_idx(fpr_rd_idx), .rd_data(fpr_rd_data),
        .wr_en(fpr_wr_en), .wr_idx(fpr_wr_idx), .wr_data(fpr_wr_data)
    );

    assign fetch_valid = !busy;

    assert_gap_pc_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(fetch_pc));

    assert_gap_fp_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(cur_fp));
endmodule

// File: tb/task_frame_regfile_tb.sv
`timescale 1ns/1ps
module task_frame_regfile_tb;
    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [31:0] STRIDE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        wr_en = 1'b0, psr_wr_en = 1'b0, fpr_wr_en = 1'b0, fcc_wr_en = 1'b0;
    logic [31:0] psr_wr_data = '0, psr_rd_data, fpr_rd_data, fpr_wr_data = '0;
    logic [2:0]  fpr_rd_idx = '0, fpr_wr_idx = '0;
    logic [1:0]  fcc_wr_data = '0, fcc_rd_data, fp_op = '0, fp_load_val = '0, cur_fp;
    logic        switch_req = 1'b0, pipe_drained = 1'b0, pc_step = 1'b0, trap_take = 1'b0;
    logic [31:0] trap_vec = '0, fetch_pc;
    logic        fetch_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    task_frame_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_rd_data(psr_rd_data),
        .fpr_rd_idx(fpr_rd_idx), .fpr_rd_data(fpr_rd_data),
        .fpr_wr_en(fpr_wr_en), .fpr_wr_idx(fpr_wr_idx), .fpr_wr_data(fpr_wr_data),
        .fcc_wr_en(fcc_wr_en), .fcc_wr_data(fcc_wr_data), .fcc_rd_data(fcc_rd_data),
        .fp_op(fp_op), .fp_load_val(fp_load_val), .cur_fp(cur_fp),
        .switch_req(switch_req), .pipe_drained(pipe_drained),
        .pc_step(pc_step), .trap_take(trap_take), .trap_vec(trap_vec),
        .fetch_pc(fetch_pc), .fetch_valid(fetch_valid)
    );

    // Behavioural reference state
    int          m_fp, m_gap;
    logic [31:0] m_glb [8];
    logic [31:0] m_loc [4][24];
    logic [31:0] m_pc [4], m_npc [4], m_psr [4];
    logic [31:0] m_fpr [32];
    logic [1:0]  m_fcc [4];

    task automatic model_reset();
        m_fp = 0; m_gap = 0;
        foreach (m_glb[i]) m_glb[i] = '0;
        foreach (m_fpr[i]) m_fpr[i] = '0;
        for (int f = 0; f < 4; f++) begin
            for (int r = 0; r < 24; r++) m_loc[f][r] = '0;
            m_pc[f]  = BASE + STRIDE * f;
            m_npc[f] = m_pc[f] + 4;
            m_psr[f] = '0;
            m_fcc[f] = '0;
        end
    endtask

    task automatic model_clock();
        if (wr_en) begin
            if (wr_idx < 8) m_glb[wr_idx] = wr_data;
            else m_loc[m_fp][wr_idx - 8] = wr_data;
        end
        if (psr_wr_en) m_psr[m_fp] = psr_wr_data;
        if (fcc_wr_en) m_fcc[m_fp] = fcc_wr_data;
        if (fpr_wr_en) m_fpr[m_fp * 8 + fpr_wr_idx] = fpr_wr_data;
        if (m_gap > 0) begin
            m_gap--;
        end else if (switch_req && pipe_drained) begin
            m_fp = (m_fp + 1) % 4;
            m_gap = 4;
        end else begin
            if (trap_take) begin
                m_pc[m_fp] = trap_vec; m_npc[m_fp] = trap_vec + 4;
            end else if (pc_step) begin
                m_pc[m_fp] = m_npc[m_fp]; m_npc[m_fp] = m_npc[m_fp] + 4;
            end
            case (fp_op)
                2'd1: m_fp = (m_fp + 1) % 4;
                2'd2: m_fp = (m_fp + 3) % 4;
                2'd3: m_fp = fp_load_val;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_clock();
    end

    function automatic logic [31:0] m_read(input logic [4:0] idx);
        if (idx < 8) return m_glb[idx];
        return m_loc[m_fp][idx - 8];
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 R5 R9 cur_fp", 32'(cur_fp), 32'(m_fp));
        chk("R9 R10 fetch_valid", 32'(fetch_valid), 32'(m_gap == 0));
        chk("R6 R7 R9 fetch_pc", fetch_pc, m_pc[m_fp]);
        chk("R2 R3 rd_data_a", rd_data_a, m_read(rd_idx_a));
        chk("R2 R3 rd_data_b", rd_data_b, m_read(rd_idx_b));
        chk("R11 psr", psr_rd_data, m_psr[m_fp]);
        chk("R12 fpr", fpr_rd_data, m_fpr[m_fp * 8 + fpr_rd_idx]);
        chk("R12 fcc", 32'(fcc_rd_data), 32'(m_fcc[m_fp]));
    endtask

    task automatic quiet();
        wr_en = 0; psr_wr_en = 0; fpr_wr_en = 0; fcc_wr_en = 0;
        fp_op = 2'd0; switch_req = 0; pc_step = 0; trap_take = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 fp after reset", 32'(cur_fp), 32'd0);
        chk("R1 fetch_valid after reset", 32'(fetch_valid), 32'd1);
        chk("R1 fetch_pc after reset", fetch_pc, BASE);
        chk("R1 psr after reset", psr_rd_data, 32'd0);
        compare_all();

        // R2 global written in frame 0, read in frame 1
        wr_en = 1; wr_idx = 5'd3; wr_data = 32'hA5A5_0003; tick();
        fp_op = 2'd1; rd_idx_a = 5'd3; tick();
        chk("R2 global seen from frame 1", rd_data_a, 32'hA5A5_0003);
        // R3 local in frame 1 invisible in frame 0
        wr_en = 1; wr_idx = 5'd10; wr_data = 32'h1111_000A; rd_idx_b = 5'd10; tick();
        chk("R3 local in own frame", rd_data_b, 32'h1111_000A);
        fp_op = 2'd2; tick();
        chk("R3 local hidden in frame 0", rd_data_b, 32'd0);
        // R4 wrap and R5 load
        fp_op = 2'd2; tick();
        chk("R4 down wrap 0 to 3", 32'(cur_fp), 32'd3);
        fp_op = 2'd1; tick();
        chk("R4 up wrap 3 to 0", 32'(cur_fp), 32'd0);
        fp_op = 2'd3; fp_load_val = 2'd2; tick();
        chk("R5 load fp", 32'(cur_fp), 32'd2);
        // R6 step and R7 trap in frame 2
        pc_step = 1; tick();
        chk("R6 step", fetch_pc, BASE + 2 * STRIDE + 4);
        trap_take = 1; pc_step = 1; trap_vec = 32'h0000_8000; tick();
        chk("R7 trap wins", fetch_pc, 32'h0000_8000);
        chk("R7 fp unchanged", 32'(cur_fp), 32'd2);
        // R8 no drain: no switch
        switch_req = 1; pipe_drained = 0; tick();
        chk("R8 ignored without drain", 32'(cur_fp), 32'd2);
        // R9 switch to frame 3 and R10 gap behaviour
        switch_req = 1; pipe_drained = 1; fp_op = 2'd1; pc_step = 1; tick();
        chk("R9 moved to next frame", 32'(cur_fp), 32'd3);
        chk("R10 op ignored on accept edge", fetch_pc, BASE + 3 * STRIDE);
        for (int k = 0; k < 3; k++) begin
            switch_req = 1; pc_step = 1; trap_take = 1; fp_op = 2'd3; fp_load_val = 2'd0; tick();
            chk("R10 gap holds", 32'(fetch_valid), 32'd0);
        end
        tick();
        chk("R9 fetch resumes after four", 32'(fetch_valid), 32'd1);
        chk("R9 new frame pc", fetch_pc, BASE + 3 * STRIDE);
        // R9 outgoing chain kept: go back to frame 2
        fp_op = 2'd2; tick();
        chk("R9 outgoing chain kept", fetch_pc, 32'h0000_8000);
        // R11 R12 per-frame side state
        psr_wr_en = 1; psr_wr_data = 32'hC0DE_0002; fcc_wr_en = 1; fcc_wr_data = 2'b10;
        fpr_wr_en = 1; fpr_wr_idx = 3'd5; fpr_wr_data = 32'h3F80_0000; fpr_rd_idx = 3'd5; tick();
        chk("R11 psr own frame", psr_rd_data, 32'hC0DE_0002);
        chk("R12 fpr own group", fpr_rd_data, 32'h3F80_0000);
        fp_op = 2'd1; tick();
        chk("R11 psr other frame", psr_rd_data, 32'd0);
        chk("R12 fpr other group", fpr_rd_data, 32'd0);
        chk("R12 fcc other frame", 32'(fcc_rd_data), 32'd0);

        // Mixed pseudo-random phase
        for (int n = 0; n < 3000; n++) begin
            wr_en = ($urandom_range(0, 2) == 0);
            wr_idx = 5'($urandom_range(0, 31));
            wr_data = $urandom();
            rd_idx_a = 5'($urandom_range(0, 31));
            rd_idx_b = 5'($urandom_range(0, 31));
            psr_wr_en = ($urandom_range(0, 5) == 0);
            psr_wr_data = $urandom();
            fpr_wr_en = ($urandom_range(0, 3) == 0);
            fpr_wr_idx = 3'($urandom_range(0, 7));
            fpr_wr_data = $urandom();
            fpr_rd_idx = 3'($urandom_range(0, 7));
            fcc_wr_en = ($urandom_range(0, 5) == 0);
            fcc_wr_data = 2'($urandom_range(0, 3));
            fp_op = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            fp_load_val = 2'($urandom_range(0, 3));
            switch_req = ($urandom_range(0, 6) == 0);
            pipe_drained = ($urandom_range(0, 1) == 0);
            pc_step = ($urandom_range(0, 1) == 0);
            trap_take = ($urandom_range(0, 15) == 0);
            trap_vec = {$urandom_range(0, 65535), 16'h0} ;
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
        quiet();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule